// File: doc/BRIEF.md
# Code-Density Nonlinearity Histogram Engine

This block measures how evenly the fine bins of a tapped delay-line time converter share the clock period. While acquiring, it takes a stream of fine-bin codes produced by hits that have no timing relation to the clock, such as coincidences from a radioactive source or cosmic rays, and counts how many land in each bin. A perfect line fills every bin equally, so any departure from uniform occupancy measures that bin's width error.

When acquisition ends, either on a command or because the number of counted hits reaches a programmed target, the engine walks the bins in ascending order. For each bin it derives the differential nonlinearity against the uniform expectation (total hits divided by the number of bins) with a sequential restoring divider, adds it into the running integral nonlinearity, and emits one output beat per bin with both values in signed Q8.8 (256 means one LSB). A healthy line stays within one LSB on both figures. Codes outside the bin range are dropped and counted apart. Saturated bins and an empty histogram are flagged.

Top module: `code_density_dnl`

## Requirements
- R1: After reset the engine is idle (`acquiring`=0, `busy`=0) and `out_valid`, `sat_flag`, `empty_err` and `overflow_count` are 0. Hits presented while idle change no count.
- R2: A `clear` pulse while idle or acquiring zeroes every bin count, the total, `overflow_count`, `sat_flag` and `empty_err`, and from the next cycle the engine is acquiring.
- R3: While acquiring, each cycle with `hit_valid`=1 and a code below NUM_BINS adds one to that bin's count and to the total.
- R4: A valid hit with a code of NUM_BINS or above changes no bin count or total and adds one to `overflow_count`, which holds at its all-ones value.
- R5: A bin count holds at 2^CNT_W-1. A hit on a full bin changes neither that count nor the total. `sat_flag` rises when any bin becomes full and stays high until the next clear.
- R6: A `compute` pulse ends acquisition; a hit presented in the same cycle or later is not counted.
- R7: With `target_count` nonzero, the hit that makes the total equal to it is counted, acquisition ends at once, and the compute phase starts without a command.
- R8: If the total is zero when compute is requested, `empty_err` rises, no output beat appears, and the engine returns to idle.
- R9: The compute phase emits exactly one beat per bin, bins 0 to NUM_BINS-1 in order, with `out_last`=1 only on the last. For N total hits and n hits in bin i, `out_dnl` is 256*(NUM_BINS*n - N)/N truncated toward zero, as a two's-complement 16-bit value.
- R10: `out_inl` for bin i is the sum of the `out_dnl` values of bins 0 to i in the same pass.
- R11: A compute request while idle repeats the pass on the retained counts. `clear` and `compute` pulses while `busy`=1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_valid | input | 1 | Hit code strobe |
| hit_code | input | CODE_W | Fine-bin code of the hit |
| clear | input | 1 | Zero the histogram and start acquiring |
| compute | input | 1 | Stop acquiring and start the nonlinearity pass |
| target_count | input | CNT_W+CODE_W | Total at which acquisition stops by itself; 0 disables |
| acquiring | output | 1 | Hits are being counted |
| busy | output | 1 | Compute pass in progress |
| out_valid | output | 1 | One bin result is on the outputs |
| out_last | output | 1 | Marks the beat of the final bin |
| out_bin | output | CODE_W | Bin index of the beat |
| out_dnl | output | 16 | Differential nonlinearity, signed Q8.8 |
| out_inl | output | 16 | Integral nonlinearity, signed Q8.8 |
| sat_flag | output | 1 | Some bin count is at its ceiling |
| overflow_count | output | OVF_W | Count of out-of-range codes, saturating |
| empty_err | output | 1 | Compute was requested with no hits counted |

## Verification
A flat fill gives zero DNL and INL everywhere and separates an exact expected-count divide from an off-by-one. A ramp-shaped fill with interleaved out-of-range codes gives mixed-sign results, which expose sign and truncation faults and show the overflow path is kept apart. A single-bin spike pushes one DNL to its maximum and all others to -1 LSB, which tests the INL accumulation over a wide swing. A fill that clips one bin, a run that stops on the target, and a repeat pass on retained counts after stray hits and commands show which hits the histogram must refuse.

// File: rtl/cdh_pkg.sv
package cdh_pkg;
    localparam int FRAC_W = 8;
    localparam int FIX_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_LOAD,
        ST_WAIT
    } phase_e;
endpackage

// File: rtl/cdh_div.sv
module cdh_div #(
    parameter int NUM_W = 42,
    parameter int DEN_W = 29,
    parameter int QO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             done,
    output logic [QO_W-1:0]  quotient
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic              run;
        logic              fin;
        logic [STEP_W-1:0] step;
        logic [DEN_W-1:0]  den;
        logic [DEN_W-1:0]  rem;
        logic [NUM_W-1:0]  qt;
    } div_s;

    div_s div_d, div_q;
    logic [DEN_W:0] trial, less;

    always_comb begin
        div_d     = div_q;
        div_d.fin = 1'b0;
        trial     = {div_q.rem, div_q.qt[NUM_W-1]};
        less      = trial - {1'b0, div_q.den};
        if (start) begin
            div_d.run  = 1'b1;
            div_d.step = '0;
            div_d.den  = divisor;
            div_d.rem  = '0;
            div_d.qt   = dividend;
        end else if (div_q.run) begin
            if (trial >= {1'b0, div_q.den}) begin
                div_d.rem = less[DEN_W-1:0];
                div_d.qt  = {div_q.qt[NUM_W-2:0], 1'b1};
            end else begin
                div_d.rem = trial[DEN_W-1:0];
                div_d.qt  = {div_q.qt[NUM_W-2:0], 1'b0};
            end
            if (div_q.step == STEP_W'(NUM_W - 1)) begin
                div_d.run = 1'b0;
                div_d.fin = 1'b1;
            end else begin
                div_d.step = div_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done     = div_q.fin;
    assign quotient = div_q.qt[QO_W-1:0];

    // R8: a pass only ever divides by a nonzero total
    assert_div_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> divisor != '0);
    // R9: each division reports completion for a single cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/cdh_hist.sv
module cdh_hist #(
    parameter int NUM_BINS = 24,
    parameter int CODE_W   = 5,
    parameter int CNT_W    = 24,
    parameter int OVF_W    = 16,
    parameter int TOT_W    = CNT_W + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic              hit_valid,
    input  logic [CODE_W-1:0] hit_code,
    input  logic [CODE_W-1:0] rd_idx,
    output logic [CNT_W-1:0]  rd_count,
    output logic [TOT_W-1:0]  total,
    output logic [TOT_W-1:0]  total_next,
    output logic              accepted,
    output logic [OVF_W-1:0]  ovf_count,
    output logic              sat_flag
);
    localparam logic [CODE_W-1:0] LAST_BIN = CODE_W'(NUM_BINS - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [OVF_W-1:0]  OVF_MAX  = '1;

    typedef struct packed {
        logic [NUM_BINS-1:0][CNT_W-1:0] cnt;
        logic [TOT_W-1:0]               total;
        logic [OVF_W-1:0]               ovf;
        logic                           sat;
    } hist_s;

    hist_s h_d, h_q;
    logic  in_range;

    always_comb begin
        h_d      = h_q;
        accepted = 1'b0;
        in_range = hit_code <= LAST_BIN;
        if (clear) begin
            h_d = '0;
        end else if (enable && hit_valid) begin
            if (in_range) begin
                for (int b = 0; b < NUM_BINS; b++) begin
                    if (hit_code == CODE_W'(b) && h_q.cnt[b] != CNT_MAX) begin
                        h_d.cnt[b] = h_q.cnt[b] + 1'b1;
                        h_d.total  = h_q.total + 1'b1;
                        accepted   = 1'b1;
                        if (h_q.cnt[b] == CNT_MAX - 1'b1) h_d.sat = 1'b1;
                    end
                end
            end else if (h_q.ovf != OVF_MAX) begin
                h_d.ovf = h_q.ovf + 1'b1;
            end
        end
    end

    always_comb begin
        rd_count = '0;
        for (int b = 0; b < NUM_BINS; b++) begin
            if (rd_idx == CODE_W'(b)) rd_count = h_q.cnt[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign total      = h_q.total;
    assign total_next = h_d.total;
    assign ovf_count  = h_q.ovf;
    assign sat_flag   = h_q.sat;

    // R5: a full bin stays full until cleared
    for (genvar g = 0; g < NUM_BINS; g++) begin : g_sat_chk
        assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !clear && h_q.cnt[g] == CNT_MAX |=> h_q.cnt[g] == CNT_MAX);
    end

    // R4: the overflow count moves only on an out-of-range hit or a clear
    assert_ovf_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !(enable && hit_valid && hit_code > LAST_BIN) |=> $stable(h_q.ovf));

    // R6: outside acquisition the total never changes
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !enable |=> $stable(h_q.total));
endmodule

// File: rtl/code_density_dnl.sv
module code_density_dnl
    import cdh_pkg::*;
#(
    parameter int NUM_BINS = 24,
    parameter int CODE_W   = 5,
    parameter int CNT_W    = 24,
    parameter int OVF_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hit_valid,
    input  logic [CODE_W-1:0]       hit_code,
    input  logic                    clear,
    input  logic                    compute,
    input  logic [CNT_W+CODE_W-1:0] target_count,
    output logic                    acquiring,
    output logic                    busy,
    output logic                    out_valid,
    output logic                    out_last,
    output logic [CODE_W-1:0]       out_bin,
    output logic signed [FIX_W-1:0] out_dnl,
    output logic signed [FIX_W-1:0] out_inl,
    output logic                    sat_flag,
    output logic [OVF_W-1:0]        overflow_count,
    output logic                    empty_err
);
    localparam int TOT_W = CNT_W + CODE_W;
    localparam int NUM_W = CODE_W + TOT_W + FRAC_W;
    localparam logic [CODE_W-1:0] LAST_BIN = CODE_W'(NUM_BINS - 1);

    typedef struct packed {
        phase_e                  phase;
        logic [CODE_W-1:0]       bin;
        logic signed [FIX_W-1:0] inl;
        logic                    neg;
        logic                    out_valid;
        logic                    out_last;
        logic [CODE_W-1:0]       out_bin;
        logic signed [FIX_W-1:0] out_dnl;
        logic signed [FIX_W-1:0] out_inl;
        logic                    empty_err;
    } ctl_s;

    ctl_s c_d, c_q;

    logic              open_phase, hist_clear, hist_en, hit_acc;
    logic [CNT_W-1:0]  rd_count;
    logic [TOT_W-1:0]  total, total_next, scaled, mag;
    logic [NUM_W-1:0]  dividend;
    logic              div_start, div_done;
    logic [FIX_W-1:0]  quot;
    logic signed [FIX_W-1:0] dnl_val, inl_val;

    assign open_phase = (c_q.phase == ST_IDLE) || (c_q.phase == ST_ACQ);
    assign hist_clear = clear && open_phase;
    assign hist_en    = (c_q.phase == ST_ACQ) && !compute && !clear;

    cdh_hist #(
        .NUM_BINS(NUM_BINS), .CODE_W(CODE_W), .CNT_W(CNT_W),
        .OVF_W(OVF_W), .TOT_W(TOT_W)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (hist_clear),
        .enable     (hist_en),
        .hit_valid  (hit_valid),
        .hit_code   (hit_code),
        .rd_idx     (c_q.bin),
        .rd_count   (rd_count),
        .total      (total),
        .total_next (total_next),
        .accepted   (hit_acc),
        .ovf_count  (overflow_count),
        .sat_flag   (sat_flag)
    );

    // Bin deviation from uniform, scaled so that the divide by N yields Q8.8
    assign scaled    = TOT_W'(rd_count) * TOT_W'(NUM_BINS);
    assign mag       = (scaled < total) ? (total - scaled) : (scaled - total);
    assign dividend  = {{CODE_W{1'b0}}, mag, {FRAC_W{1'b0}}};
    assign div_start = (c_q.phase == ST_LOAD);

    cdh_div #(.NUM_W(NUM_W), .DEN_W(TOT_W), .QO_W(FIX_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (dividend),
        .divisor  (total),
        .done     (div_done),
        .quotient (quot)
    );

    assign dnl_val = c_q.neg ? -$signed(quot) : $signed(quot);
    assign inl_val = c_q.inl + dnl_val;

    always_comb begin
        c_d           = c_q;
        c_d.out_valid = 1'b0;
        c_d.out_last  = 1'b0;
        case (c_q.phase)
            ST_IDLE, ST_ACQ: begin
                if (clear) begin
                    c_d.phase     = ST_ACQ;
                    c_d.empty_err = 1'b0;
                end else if (compute) begin
                    if (total == '0) begin
                        c_d.phase     = ST_IDLE;
                        c_d.empty_err = 1'b1;
                    end else begin
                        c_d.phase     = ST_LOAD;
                        c_d.bin       = '0;
                        c_d.inl       = '0;
                        c_d.empty_err = 1'b0;
                    end
                end else if (c_q.phase == ST_ACQ && hit_acc &&
                             target_count != '0 && total_next == target_count) begin
                    c_d.phase = ST_LOAD;
                    c_d.bin   = '0;
                    c_d.inl   = '0;
                end
            end
            ST_LOAD: begin
                c_d.neg   = scaled < total;
                c_d.phase = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_done) begin
                    c_d.out_valid = 1'b1;
                    c_d.out_bin   = c_q.bin;
                    c_d.out_dnl   = dnl_val;
                    c_d.out_inl   = inl_val;
                    c_d.inl       = inl_val;
                    if (c_q.bin == LAST_BIN) begin
                        c_d.out_last = 1'b1;
                        c_d.phase    = ST_IDLE;
                    end else begin
                        c_d.bin   = c_q.bin + 1'b1;
                        c_d.phase = ST_LOAD;
                    end
                end
            end
            default: c_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign acquiring = (c_q.phase == ST_ACQ);
    assign busy      = (c_q.phase == ST_LOAD) || (c_q.phase == ST_WAIT);
    assign out_valid = c_q.out_valid;
    assign out_last  = c_q.out_last;
    assign out_bin   = c_q.out_bin;
    assign out_dnl   = c_q.out_dnl;
    assign out_inl   = c_q.out_inl;
    assign empty_err = c_q.empty_err;

    assert_last_bin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> out_bin == LAST_BIN);
    assert_dnl_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_dnl >= -16'sd256);
    assert_inl_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bin == '0 |-> out_inl == out_dnl);
    assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty_err |-> !out_valid && !busy);
endmodule

// File: tb/tb_code_density_dnl.sv
module tb_code_density_dnl;
    localparam int CLK_PERIOD = 10;
    localparam int M     = 12;
    localparam int CW    = 4;
    localparam int CNTW  = 6;
    localparam int OVW   = 4;
    localparam int TW    = CNTW + CW;
    localparam int CMAX  = (1 << CNTW) - 1;
    localparam int OVMAX = (1 << OVW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hit_valid = 1'b0;
    logic [CW-1:0] hit_code = '0;
    logic clear = 1'b0, compute = 1'b0;
    logic [TW-1:0] target_count = '0;
    logic acquiring, busy, out_valid, out_last, sat_flag, empty_err;
    logic [CW-1:0] out_bin;
    logic signed [15:0] out_dnl, out_inl;
    logic [OVW-1:0] overflow_count;

    code_density_dnl #(.NUM_BINS(M), .CODE_W(CW), .CNT_W(CNTW), .OVF_W(OVW)) dut (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_code(hit_code),
        .clear(clear), .compute(compute), .target_count(target_count),
        .acquiring(acquiring), .busy(busy), .out_valid(out_valid), .out_last(out_last),
        .out_bin(out_bin), .out_dnl(out_dnl), .out_inl(out_inl), .sat_flag(sat_flag),
        .overflow_count(overflow_count), .empty_err(empty_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {int bin; int dnl; int inl; bit last;} beat_t;
    beat_t exp_q[$];

    int n_chk = 0, n_bad = 0, cyc = 0;
    int mcnt[M];
    int mtot = 0, movf = 0;
    bit msat = 0, macq = 0;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push_expected();
        int inl = 0;
        for (int i = 0; i < M; i++) begin
            int dnl;
            beat_t b;
            dnl = (256 * (M * mcnt[i] - mtot)) / mtot;
            inl += dnl;
            b.bin = i; b.dnl = dnl; b.inl = inl; b.last = (i == M - 1);
            exp_q.push_back(b);
        end
    endtask

    // Scoreboard monitor: compares each result beat against the queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R9", "unexpected beat bin", int'(out_bin), -1);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                check(int'(out_bin) == e.bin && int'(out_dnl) == e.dnl &&
                      int'(out_inl) == e.inl && out_last == e.last,
                      "R9 R10", $sformatf("bin %0d dnl/inl %0d/%0d last %0d", out_bin,
                      out_dnl, out_inl, out_last), e.dnl * 100000 + e.inl, e.bin);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(0, "WATCHDOG", "cycles", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic hit(int c);
        @(negedge clk);
        hit_valid = 1'b1;
        hit_code  = CW'(c);
        if (macq) begin
            if (c < M) begin
                if (mcnt[c] < CMAX) begin
                    mcnt[c]++;
                    mtot++;
                    if (mcnt[c] == CMAX) msat = 1;
                    if (target_count != 0 && mtot == int'(target_count)) begin
                        macq = 0;
                        push_expected();
                    end
                end
            end else if (movf < OVMAX) begin
                movf++;
            end
        end
    endtask

    task automatic hits_off();
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        hit_valid = 1'b0;
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        for (int i = 0; i < M; i++) mcnt[i] = 0;
        mtot = 0; movf = 0; msat = 0; macq = 1;
    endtask

    task automatic do_compute();
        @(negedge clk);
        hit_valid = 1'b0;
        compute = 1'b1;
        macq = 0;
        if (mtot != 0) push_expected();
        @(negedge clk);
        compute = 1'b0;
    endtask

    task automatic wait_idle(string req);
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, req, "beats still owed", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!acquiring && !busy, "R1", "acquiring|busy", {acquiring, busy}, 0);
        check(!out_valid, "R1", "out_valid", out_valid, 0);
        check(!sat_flag && !empty_err, "R1", "sat|empty", {sat_flag, empty_err}, 0);
        check(overflow_count == 0, "R1", "overflow_count", overflow_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: hits while idle are not counted, in range or out
        for (int k = 0; k < 6; k++) hit(k * 3);
        hits_off();
        check(overflow_count == 0, "R1", "idle overflow", overflow_count, 0);
        // R8: empty total at compute
        do_compute();
        @(negedge clk);
        check(empty_err == 1'b1, "R8", "empty_err", empty_err, 1);
        wait_idle("R8");

        // R2: clear starts acquisition and drops the error
        do_clear();
        check(acquiring && !empty_err, "R2", "acq/empty", {acquiring, empty_err}, 2);
        // R3 flat fill
        for (int r = 0; r < 5; r++) for (int b = 0; b < M; b++) hit(b);
        hits_off();
        do_compute();
        @(negedge clk);
        check(!acquiring, "R6", "acquiring after compute", acquiring, 0);
        wait_idle("R3");

        // R3 R4 ramp fill with out-of-range codes mixed in
        do_clear();
        check(overflow_count == 0 && !sat_flag, "R2", "ovf/sat after clear",
              overflow_count, 0);
        for (int b = 0; b < M; b++) begin
            for (int r = 0; r <= b % 4; r++) hit(b);
            hit(M + (b % 4));
            hit(15);
        end
        hits_off();
        check(int'(overflow_count) == OVMAX, "R4", "overflow_count saturated",
              overflow_count, OVMAX);
        do_compute();
        // R6: hits after the stop are ignored, seen through the repeat pass
        for (int k = 0; k < 8; k++) hit(0);
        hits_off();
        wait_idle("R4");
        do_compute();
        // R11: clear and compute during the pass are ignored
        repeat (4) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        compute = 1'b1;
        @(negedge clk);
        compute = 1'b0;
        check(busy && !acquiring, "R11", "busy/acq after stray cmds",
              {busy, acquiring}, 2);
        wait_idle("R11");
        check(int'(overflow_count) == OVMAX, "R11", "overflow kept", overflow_count, OVMAX);

        // R7: auto stop on target
        do_clear();
        target_count = TW'(30);
        for (int k = 0; k < 40; k++) hit((k * 5) % M);
        hits_off();
        check(!acquiring, "R7", "acquiring after target", acquiring, 0);
        wait_idle("R7");
        target_count = '0;

        // R5: clipping one bin
        do_clear();
        for (int k = 0; k < 70; k++) hit(3);
        for (int r = 0; r < 2; r++) for (int b = 0; b < M; b++) hit(b);
        hits_off();
        check(sat_flag == msat, "R5", "sat_flag", sat_flag, msat);
        do_compute();
        wait_idle("R5");

        // R9 R10: single-bin spike
        do_clear();
        check(!sat_flag, "R2", "sat cleared", sat_flag, 0);
        for (int k = 0; k < 10; k++) hit(0);
        hits_off();
        do_compute();
        wait_idle("R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule